// File: doc/BRIEF.md
# Predicated Signed-Halfword Vector Load Sequencer

This block carries out one predicated, contiguous vector load of signed 16-bit values. It handles one element per step. A start pulse supplies a 32-bit instruction word, a 64-bit base, a 64-bit running index and a byte-granular predicate mask. The block checks the instruction word and takes the element width (32 or 64 bits) from one opcode bit. It then walks the elements from lane 0 upward. For each active lane it issues one halfword read on a request/response memory port and sign-extends the returned data into that lane. Inactive lanes read nothing and are filled with zeros.

The controller is a six-state machine:
- **IDLE** waits for `start`. It goes to **STEP** when the word is legal, or to **BAD** when it is not.
- **STEP** looks at the predicate bit of the current element. An active element goes to **REQ**. An inactive element is zero-written and skipped: the block stays in **STEP**, or goes to **FIN** after the last element.
- **REQ** holds a read request until `mem_req_ready`, then goes to **WAIT**.
- **WAIT** holds until `mem_rsp_valid`, writes the lane, then goes back to **STEP**, or to **FIN** after the last element.
- **FIN** pulses `done` for one cycle and returns to **IDLE**.
- **BAD** pulses `undef` for one cycle and returns to **IDLE**.

The caller's index is copied at start and advanced only inside the block. It is never handed back. The vector length `VL` is a parameter. The predicate has VL/8 bits.

Top module: `hword_vload_seq`

## Requirements
- R1: A start is legal only when instr[31:22] = 10'b1010010100, instr[15:13] = 3'b010 and instr[20:16] is not 5'b11111. An illegal start raises `undef` for exactly one cycle, in the cycle after the start. It issues no memory request, gives no `done`, and leaves `result` unchanged.
- R2: instr[21] = 1 selects 32-bit elements (VL/32 elements). instr[21] = 0 selects 64-bit elements (VL/64 elements).
- R3: The read address of element e is base + (index + e) × 2, computed modulo 2^64.
- R4: The internal index advances by one after every element, whether the element is active or inactive.
- R5: An inactive element issues no memory request, and its lane reads as all zeros.
- R6: The 16-bit response is sign-extended to the full element width in its lane. Element e occupies result bits [e×esize +: esize].
- R7: Elements are processed strictly in ascending order, starting at element 0.
- R8: Element e is active exactly when predicate bit e × (esize/8) is 1. All other predicate bits are ignored.
- R9: `mem_req_valid` stays high with a stable address until `mem_req_ready`. At most one read is outstanding at any time.
- R10: `done` is a one-cycle pulse after the last element. `result` then holds its value until the next accepted start.
- R11: A `start` while the block is busy is ignored. It does not change the running operation, its reads or its result.
- R12: After reset, `done`, `undef` and `mem_req_valid` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only in IDLE) |
| instr | input | 32 | Instruction word |
| base | input | 64 | Base address |
| index | input | 64 | Starting element index (unsigned) |
| pred | input | VL/8 | Predicate, one bit per vector byte |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Halfword read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Returned halfword |
| result | output | VL | Assembled destination vector |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The main symptom of a wrong state is a wrong read address, and it appears on the memory port at the very first request that follows. This happens, for example, when the element counter or the index is off, or when the predicate is read at the wrong bit. A wrong lane count or a wrong active decision shows up as a request the scoreboard did not expect, or as one that never comes. A controller stuck in the wrong state shows up as a missing or doubled `done` or `undef` pulse within a few cycles of the last element. Corrupted lane assembly stays hidden until the `done` cycle, when the whole vector is compared.

// File: rtl/hvl_pkg.sv
package hvl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_REQ,
        ST_WAIT,
        ST_FIN,
        ST_BAD
    } hvl_state_t;

    localparam logic [9:0] OPC_HIGH = 10'b1010010100;
    localparam logic [2:0] OPC_MID  = 3'b010;
    localparam logic [4:0] IDX_ZR   = 5'b11111;
endpackage

// File: rtl/hvl_decode.sv
module hvl_decode
    import hvl_pkg::*;
(
    input  logic [31:0] instr,
    output logic        legal,
    output logic        elem64
);
    logic opc_ok;

    always_comb begin
        opc_ok = (instr[31:22] == OPC_HIGH) && (instr[15:13] == OPC_MID);
        legal  = opc_ok && (instr[20:16] != IDX_ZR);
        elem64 = ~instr[21];
    end
endmodule

// File: rtl/hvl_addr.sv
module hvl_addr (
    input  logic [63:0] base,
    input  logic [63:0] idx,
    output logic [63:0] addr
);
    always_comb addr = base + {idx[62:0], 1'b0};
endmodule

// File: rtl/hvl_lanes.sv
module hvl_lanes #(
    parameter int VL = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic                       elem64,
    input  logic                       active,
    input  logic [$clog2(VL/32)-1:0]   elem,
    input  logic [15:0]                hword,
    output logic [VL-1:0]              result
);
    localparam int NW = VL / 32;
    localparam int EW = $clog2(NW);

    logic [31:0] lo_w;
    logic [31:0] hi_w;

    always_comb begin
        lo_w = {{16{hword[15]}}, hword};
        hi_w = {32{hword[15]}};
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic        hit;
        logic [31:0] wdata;
        logic [31:0] word_q;

        always_comb begin
            hit = elem64 ? (elem == EW'(w / 2)) : (elem == EW'(w));
            if (!active)
                wdata = 32'd0;
            else if (elem64 && (w % 2 == 1))
                wdata = hi_w;
            else
                wdata = lo_w;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= 32'd0;
            else if (clr)
                word_q <= 32'd0;
            else if (wr_en && hit)
                word_q <= wdata;
        end

        assign result[w*32 +: 32] = word_q;
    end
endmodule

// File: rtl/hword_vload_seq.sv
module hword_vload_seq
    import hvl_pkg::*;
#(
    parameter int VL = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [63:0]       base,
    input  logic [63:0]       index,
    input  logic [VL/8-1:0]   pred,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [15:0]       mem_rsp_data,
    output logic [VL-1:0]     result,
    output logic              done,
    output logic              undef
);
    localparam int NW  = VL / 32;
    localparam int EW  = $clog2(NW);
    localparam int PL  = VL / 8;
    localparam int PIW = $clog2(PL);

    hvl_state_t st, st_nx;

    logic [EW-1:0]   elem;
    logic [63:0]     base_q;
    logic [63:0]     idx_q;
    logic [PL-1:0]   pred_q;
    logic            elem64_q;
    logic            legal;
    logic            elem64_in;
    logic            accept;
    logic            active;
    logic            last;
    logic            adv;
    logic [EW+2:0]   pbit;

    hvl_decode u_dec (
        .instr  (instr),
        .legal  (legal),
        .elem64 (elem64_in)
    );

    hvl_addr u_addr (
        .base (base_q),
        .idx  (idx_q),
        .addr (mem_req_addr)
    );

    always_comb begin
        accept = (st == ST_IDLE) && start;
        pbit   = elem64_q ? {elem, 3'b000} : {1'b0, elem, 2'b00};
        active = pred_q[pbit[PIW-1:0]];
        last   = elem64_q ? (elem == EW'(NW / 2 - 1)) : (elem == EW'(NW - 1));
        adv    = ((st == ST_STEP) && !active) || ((st == ST_WAIT) && mem_rsp_valid);
    end

    hvl_lanes #(.VL(VL)) u_lanes (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept && legal),
        .wr_en  (adv),
        .elem64 (elem64_q),
        .active (st == ST_WAIT),
        .elem   (elem),
        .hword  (mem_rsp_data),
        .result (result)
    );

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = legal ? ST_STEP : ST_BAD;
            ST_STEP: begin
                if (active)
                    st_nx = ST_REQ;
                else if (last)
                    st_nx = ST_FIN;
            end
            ST_REQ:  if (mem_req_ready) st_nx = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) st_nx = last ? ST_FIN : ST_STEP;
            ST_FIN:  st_nx = ST_IDLE;
            ST_BAD:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // outputs
    always_comb begin
        mem_req_valid = (st == ST_REQ);
        done          = (st == ST_FIN);
        undef         = (st == ST_BAD);
    end

    // operand capture and element walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem     <= '0;
            base_q   <= '0;
            idx_q    <= '0;
            pred_q   <= '0;
            elem64_q <= 1'b0;
        end else if (accept) begin
            elem     <= '0;
            base_q   <= base;
            idx_q    <= index;
            pred_q   <= pred;
            elem64_q <= elem64_in;
        end else if (adv) begin
            elem  <= elem + 1'b1;
            idx_q <= idx_q + 64'd1;
        end
    end
endmodule

// File: rtl/hvl_chk.sv
module hvl_chk #(
    parameter int VL = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [63:0]   mem_req_addr,
    input logic          mem_rsp_valid,
    input logic [VL-1:0] result,
    input logic          done,
    input logic          undef
);
    logic completed;
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            completed   <= 1'b0;
            outstanding <= 1'b0;
        end else begin
            if (start)
                completed <= 1'b0;
            else if (done)
                completed <= 1'b1;
            if (mem_req_valid && mem_req_ready)
                outstanding <= 1'b1;
            else if (mem_rsp_valid)
                outstanding <= 1'b0;
        end
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        completed && !start |=> $stable(result));

    p_undef_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> !done && !mem_req_valid);

    p_undef_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        undef |=> !undef);
endmodule

bind hword_vload_seq hvl_chk #(.VL(VL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .result        (result),
    .done          (done),
    .undef         (undef)
);

// File: tb/hword_vload_seq_tb.sv
module hword_vload_seq_tb;
    localparam int VL = 128;
    localparam int PL = VL / 8;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   instr = '0;
    logic [63:0]   base = '0;
    logic [63:0]   index = '0;
    logic [PL-1:0] pred = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [63:0]   mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [15:0]   mem_rsp_data = '0;
    logic [VL-1:0] result;
    logic          done;
    logic          undef;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];
    logic [VL-1:0] last_result = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hword_vload_seq #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .base(base), .index(index), .pred(pred),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .result(result),
        .done(done), .undef(undef)
    );

    function automatic logic [15:0] dfun(logic [63:0] a);
        return a[16:1] ^ {a[40:33], a[56:49]} ^ 16'h9C35;
    endfunction

    function automatic logic [31:0] mk(bit sz, logic [4:0] rm);
        return {10'b1010010100, sz, rm, 3'b010, 3'd2, 5'd7, 5'd3};
    endfunction

    task automatic chk(bit ok, string req, logic [VL-1:0] act, logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and request monitor (scoreboard consumer)
    initial begin
        int cyc = 0;
        bit pending = 1'b0;
        logic [63:0] paddr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = dfun(paddr);
                pending = 1'b0;
            end
            mem_req_ready = (cyc % 3) != 0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected read", VL'(mem_req_addr), '0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    // R3 R7 address order
                    chk(mem_req_addr == e, "R3 read address", VL'(mem_req_addr), VL'(e));
                end
                paddr = mem_req_addr;
                pending = 1'b1;
            end
        end
    end

    // driver: queue expected reads, run, compare outcome
    task automatic run_op(logic [31:0] ins, logic [63:0] b, logic [63:0] ix,
                          logic [PL-1:0] pr, bit exp_bad, bit busy_poke, string tag);
        logic [VL-1:0] expv = '0;
        int esize;
        int ne;
        bit seen = 1'b0;
        esize = ins[21] ? 32 : 64;
        ne = VL / esize;
        if (!exp_bad) begin
            for (int e = 0; e < ne; e++) begin
                logic [63:0] a;
                logic [15:0] d;
                a = b + ((ix + 64'(e)) << 1);
                if (pr[e * (esize / 8)]) begin
                    exp_q.push_back(a);
                    d = dfun(a);
                    if (esize == 32) expv[e*32 +: 32] = {{16{d[15]}}, d};
                    else             expv[e*64 +: 64] = {{48{d[15]}}, d};
                end
            end
        end
        @(negedge clk);
        start = 1'b1; instr = ins; base = b; index = ix; pred = pr;
        @(negedge clk);
        start = 1'b0;
        if (exp_bad) begin
            chk(undef == 1'b1, {tag, " R1 undef pulse"}, VL'(undef), VL'(1));
            chk(result == last_result, {tag, " R1 result kept"}, result, last_result);
            @(negedge clk);
            chk(undef == 1'b0, {tag, " R1 undef one cycle"}, VL'(undef), '0);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk(!seen, {tag, " R1 no done"}, VL'(seen), '0);
            chk(exp_q.size() == 0, {tag, " R1 no read"}, VL'(exp_q.size()), '0);
            return;
        end
        if (busy_poke) begin
            @(negedge clk);
            start = 1'b1; instr = mk(1'b1, 5'd1); base = 64'hDEAD_0000; pred = '1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 400 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        chk(seen, {tag, " R10 done seen"}, VL'(seen), VL'(1));
        // R2 R5 R6 R8 R11 full vector
        chk(result == expv, {tag, " R6 result vector"}, result, expv);
        chk(exp_q.size() == 0, {tag, " R2 read count"}, VL'(exp_q.size()), '0);
        @(negedge clk);
        chk(!done, {tag, " R10 done one cycle"}, VL'(done), '0);
        repeat (3) @(negedge clk);
        chk(result == expv, {tag, " R10 result held"}, result, expv);
        exp_q.delete();
        last_result = result;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R12 reset state
        chk(!done && !undef && !mem_req_valid, "R12 outputs idle",
            VL'({done, undef, mem_req_valid}), '0);
        chk(result == '0, "R12 result zero", result, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(mk(1'b1, 5'd4), 64'h1000, 64'd5, '1, 1'b0, 1'b0, "all32");
        run_op(mk(1'b0, 5'd4), 64'h8000_0000, 64'd100, 16'h0100, 1'b0, 1'b0, "r8_w64");
        run_op(mk(1'b1, 5'd9), 64'h2000, 64'd3, 16'hEEEE, 1'b0, 1'b0, "r5_none");
        run_op(mk(1'b1, 5'd9), 64'h3000, 64'd0, 16'h0100, 1'b0, 1'b0, "r4_lane2");
        run_op(mk(1'b0, 5'd0), 64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF,
               16'h0101, 1'b0, 1'b0, "r3_wrap");
        run_op(mk(1'b1, 5'd31), 64'h4000, 64'd1, '1, 1'b1, 1'b0, "r1_zr");
        run_op(mk(1'b1, 5'd2) ^ 32'h0000_4000, 64'h4000, 64'd1, '1, 1'b1, 1'b0, "r1_opc");
        run_op(mk(1'b1, 5'd2), 64'h5000, 64'd7, 16'h1011, 1'b0, 1'b1, "r11_busy");
        run_op(mk(1'b0, 5'd2), 64'h6002, 64'h7FFF, 16'h0101, 1'b0, 1'b0, "r7_w64");

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule